// File: doc/BRIEF.md
# Timestamped Edge Capture Unit

This block watches four already-synchronized input lines and records when something happens on them. A free-running 16-bit reference timer, driven by an internal divide-by-8 prescaler, supplies the timestamp. When a line that is enabled sees an event of the kind configured for it, the unit stores an entry. The entry holds the current timer value and a mask of the lines that fired in that clock cycle.

Entries go into a holding register that software reads, backed by a seven-deep first-in first-out queue. A read strobe releases the holding register, and the oldest queued entry moves forward on the same clock edge. An interrupt pulse can be set to mark either each load of the holding register or the moment the queue reaches six entries. When all eight slots are occupied, further events are lost and a sticky overflow flag records the loss.

Top module: `evcap_unit`

## Requirements
- R1: Each of the four lines has its own enable bit (`line_en_i[i]`). A disabled line never contributes to an entry, whatever it does.
- R2: Each line has a 2-bit trigger field at `line_mode_i[2i+1:2i]`. Code 00 fires on rising edges, 01 on falling edges and 10 on both edges. An edge is a change of `line_i[i]` from its value in the previous clock cycle; that value is 0 after reset.
- R3: Code 11 fires on every eighth rising edge of an enabled line. The edges are counted per line. A line's count is cleared whenever its trigger field differs from the previous cycle's value, and a rising edge in that same cycle is not counted.
- R4: `timer_o` is 0 after reset and increases by one every 8 clock cycles, wrapping at 16 bits. The first step comes on the 8th rising clock edge after reset is released.
- R5: An entry is {mask[19:16], stamp[15:0]}. The stamp is the `timer_o` value in the cycle the events occur, and bit i of the mask is set for each line i that fired in that cycle. All events in one cycle share a single entry, which becomes visible after the next clock edge.
- R6: Storage is the holding register plus 7 queued entries, and entries leave in the order they were captured. `rd_i` while `hold_vld_o` is high releases the holding entry, and the next one takes its place on that edge. `rd_i` with nothing held has no effect.
- R7: If all 8 slots remain occupied in a cycle with an event, that entry is dropped and `ovf_o` goes high until reset. A read in the same cycle frees a slot, so the event is then kept.
- R8: With `irq_sel_i` = 0, `irq_o` pulses for one cycle, together with the new `hold_data_o`, whenever the holding register receives an entry.
- R9: With `irq_sel_i` = 1, `irq_o` pulses for one cycle when a push into the queue leaves it holding exactly six entries.
- R10: During and right after reset, `hold_vld_o`, `irq_o` and `ovf_o` are 0 and `timer_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_i | input | 4 | Synchronized event lines |
| line_en_i | input | 4 | Per-line enable |
| line_mode_i | input | 8 | Per-line 2-bit trigger code |
| irq_sel_i | input | 1 | Interrupt cause: 0 holding load, 1 sixth queued entry |
| rd_i | input | 1 | Read strobe that releases the holding register |
| hold_data_o | output | 20 | Holding entry: line mask and timestamp |
| hold_vld_o | output | 1 | Holding register contains an entry |
| irq_o | output | 1 | One-cycle interrupt pulse |
| ovf_o | output | 1 | Sticky overflow flag |
| timer_o | output | 16 | Reference timer value |

## Verification
The bench aims at a read and a new event in the same cycle while all eight slots are full. A design that tested occupancy before the read would drop that event and raise the overflow flag wrongly. It also changes a line's trigger code partway through an every-eighth-edge count. A prescaler that was not cleared, or that counted the edge in the change cycle, would fire early. Events on several lines in one cycle must merge into a single entry, since splitting them would use up slots and move the sixth-entry interrupt. Reads with nothing held, and the hand-off from queue to holding register, are also covered: an error there would show up as a lost, duplicated or reordered entry, or as an interrupt pulse in the wrong cycle.

// File: rtl/evcap_pkg.sv
package evcap_pkg;
    parameter int unsigned LINES = 4;
    parameter int unsigned TS_W  = 16;

    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_BOTH  = 2'd2,
        TRIG_RISE8 = 2'd3
    } trig_e;

    typedef struct packed {
        logic [LINES-1:0] mask;
        logic [TS_W-1:0]  stamp;
    } entry_t;
endpackage

// File: rtl/evcap_timebase.sv
module evcap_timebase
    import evcap_pkg::*;
#(
    parameter int unsigned DIV = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] stamp_o
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [PW-1:0]   pre;
        logic [TS_W-1:0] tmr;
    } tb_s;

    tb_s tb_d, tb_q;

    always_comb begin
        tb_d = tb_q;
        if (tb_q.pre == PW'(DIV - 1)) begin
            tb_d.pre = '0;
            tb_d.tmr = tb_q.tmr + 1'b1;
        end else begin
            tb_d.pre = tb_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign stamp_o = tb_q.tmr;

    // R4: the timer only ever steps by one
    p_timer_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stamp_o != $past(stamp_o)) |-> (stamp_o == $past(stamp_o) + 1'b1));
    // R4: a step always lands right after the prescaler wrapped
    p_timer_rate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stamp_o != $past(stamp_o)) |-> (tb_q.pre == '0));
endmodule

// File: rtl/evcap_detect.sv
module evcap_detect
    import evcap_pkg::*;
#(
    parameter int unsigned EVERY_N = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LINES-1:0]   line_i,
    input  logic [LINES-1:0]   en_i,
    input  logic [2*LINES-1:0] mode_i,
    output logic [LINES-1:0]   hit_o
);
    localparam int unsigned CW = (EVERY_N > 1) ? $clog2(EVERY_N) : 1;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        typedef struct packed {
            logic          prev;
            logic [1:0]    mode;
            logic [CW-1:0] cnt;
        } ln_s;

        ln_s  ln_d, ln_q;
        logic rise, fall, mode_chg, hit;

        always_comb begin
            ln_d      = ln_q;
            ln_d.prev = line_i[g];
            ln_d.mode = mode_i[2*g +: 2];
            rise      = line_i[g] & ~ln_q.prev;
            fall      = ~line_i[g] & ln_q.prev;
            mode_chg  = (mode_i[2*g +: 2] != ln_q.mode);
            hit       = 1'b0;
            if (en_i[g]) begin
                case (trig_e'(mode_i[2*g +: 2]))
                    TRIG_RISE: hit = rise;
                    TRIG_FALL: hit = fall;
                    TRIG_BOTH: hit = rise | fall;
                    default: begin
                        if (!mode_chg && rise) begin
                            if (ln_q.cnt == CW'(EVERY_N - 1)) begin
                                hit      = 1'b1;
                                ln_d.cnt = '0;
                            end else begin
                                ln_d.cnt = ln_q.cnt + 1'b1;
                            end
                        end
                    end
                endcase
            end
            if (mode_chg) ln_d.cnt = '0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ln_q <= '0;
            else        ln_q <= ln_d;
        end

        assign hit_o[g] = hit;

        // R1: a disabled line never fires
        p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !en_i[g] |-> !hit_o[g]);
        // R2: a hit needs an edge on its own line
        p_hit_needs_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
            hit_o[g] |-> (line_i[g] != ln_q.prev));
        // R3: a changed trigger code leaves the edge count at zero
        p_mode_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_i[2*g +: 2] != ln_q.mode) |=> (ln_q.cnt == '0));
    end
endmodule

// File: rtl/evcap_store.sv
module evcap_store
    import evcap_pkg::*;
#(
    parameter int unsigned QDEPTH    = 7,
    parameter int unsigned IRQ_LEVEL = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] hit_i,
    input  logic [TS_W-1:0]  stamp_i,
    input  logic             rd_i,
    input  logic             irq_sel_i,
    output entry_t           hold_o,
    output logic             hold_vld_o,
    output logic             irq_o,
    output logic             ovf_o
);
    localparam int unsigned PW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
    localparam int unsigned CW = $clog2(QDEPTH + 1);

    typedef struct packed {
        entry_t [QDEPTH-1:0] mem;
        logic [PW-1:0]       rp;
        logic [PW-1:0]       wp;
        logic [CW-1:0]       cnt;
        entry_t              hold;
        logic                hvld;
        logic                irq;
        logic                ovf;
    } st_s;

    st_s st_d, st_q;
    entry_t        fresh;
    logic          ev, kept_hold, placed, loaded, pushed;
    logic [CW-1:0] occ;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(QDEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d       = st_q;
        ev         = |hit_i;
        fresh      = '{mask: hit_i, stamp: stamp_i};
        kept_hold  = st_q.hvld & ~rd_i;
        placed     = 1'b0;
        loaded     = 1'b0;
        pushed     = 1'b0;
        occ        = st_q.cnt;
        st_d.hvld  = kept_hold;
        if (!kept_hold) begin
            if (st_q.cnt != '0) begin
                st_d.hold = st_q.mem[st_q.rp];
                st_d.hvld = 1'b1;
                st_d.rp   = nxt(st_q.rp);
                occ       = st_q.cnt - 1'b1;
                loaded    = 1'b1;
            end else if (ev) begin
                st_d.hold = fresh;
                st_d.hvld = 1'b1;
                placed    = 1'b1;
                loaded    = 1'b1;
            end
        end
        if (ev && !placed) begin
            if (occ < CW'(QDEPTH)) begin
                st_d.mem[st_q.wp] = fresh;
                st_d.wp           = nxt(st_q.wp);
                occ               = occ + 1'b1;
                pushed            = 1'b1;
            end else begin
                st_d.ovf = 1'b1;
            end
        end
        st_d.cnt = occ;
        st_d.irq = irq_sel_i ? (pushed && occ == CW'(IRQ_LEVEL)) : loaded;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_o     = st_q.hold;
    assign hold_vld_o = st_q.hvld;
    assign irq_o      = st_q.irq;
    assign ovf_o      = st_q.ovf;

    // R6: queue occupancy never exceeds its depth
    p_no_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(QDEPTH));
    // R6: an unread holding entry stays put
    p_hold_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_vld_o && !rd_i) |=> (hold_vld_o && $stable(hold_o)));
    // R6: the queue only holds entries while the holding register is full
    p_hold_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0) |-> hold_vld_o);
    // R7: overflow is sticky
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ovf_o) |-> ovf_o);
    // R8: a load interrupt always comes with a held entry
    p_irq_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !$past(irq_sel_i)) |-> hold_vld_o);
    // R9: a level interrupt comes with six queued entries
    p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && $past(irq_sel_i)) |-> (st_q.cnt == CW'(IRQ_LEVEL)));
endmodule

// File: rtl/evcap_unit.sv
module evcap_unit
    import evcap_pkg::*;
#(
    parameter int unsigned TICK_DIV  = 8,
    parameter int unsigned EVERY_N   = 8,
    parameter int unsigned QDEPTH    = 7,
    parameter int unsigned IRQ_LEVEL = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LINES-1:0]        line_i,
    input  logic [LINES-1:0]        line_en_i,
    input  logic [2*LINES-1:0]      line_mode_i,
    input  logic                    irq_sel_i,
    input  logic                    rd_i,
    output logic [LINES+TS_W-1:0]   hold_data_o,
    output logic                    hold_vld_o,
    output logic                    irq_o,
    output logic                    ovf_o,
    output logic [TS_W-1:0]         timer_o
);
    logic [TS_W-1:0]  stamp;
    logic [LINES-1:0] hit;
    entry_t           hold;

    evcap_timebase #(.DIV(TICK_DIV)) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .stamp_o (stamp)
    );

    evcap_detect #(.EVERY_N(EVERY_N)) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_i),
        .en_i   (line_en_i),
        .mode_i (line_mode_i),
        .hit_o  (hit)
    );

    evcap_store #(.QDEPTH(QDEPTH), .IRQ_LEVEL(IRQ_LEVEL)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (hit),
        .stamp_i    (stamp),
        .rd_i       (rd_i),
        .irq_sel_i  (irq_sel_i),
        .hold_o     (hold),
        .hold_vld_o (hold_vld_o),
        .irq_o      (irq_o),
        .ovf_o      (ovf_o)
    );

    assign hold_data_o = hold;
    assign timer_o     = stamp;

    // R5: a fresh entry never has an empty line mask
    p_mask_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_vld_o) |-> (hold_data_o[LINES+TS_W-1:TS_W] != '0));
endmodule

// File: tb/evcap_unit_bench.sv
`timescale 1ns/100ps
module evcap_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  b_line = '0;
    logic [3:0]  b_en = '0;
    logic [7:0]  b_mode = '0;
    logic        b_sel = 1'b0;
    logic        b_rd = 1'b0;
    logic [19:0] hold_data;
    logic        hold_vld, irq, ovf;
    logic [15:0] timer;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // behavioural reference state
    int          m_tmr, m_pre;
    logic [3:0]  m_prev;
    logic [1:0]  m_mode [4];
    int          m_cnt [4];
    logic [19:0] mq[$];
    bit          m_ovf, m_irq;
    logic [31:0] rnd = 32'h1234_abcd;

    always #2.5 clk = ~clk;

    evcap_unit u_evcap_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_i      (b_line),
        .line_en_i   (b_en),
        .line_mode_i (b_mode),
        .irq_sel_i   (b_sel),
        .rd_i        (b_rd),
        .hold_data_o (hold_data),
        .hold_vld_o  (hold_vld),
        .irq_o       (irq),
        .ovf_o       (ovf),
        .timer_o     (timer)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] rand32();
        rnd = rnd ^ (rnd << 13);
        rnd = rnd ^ (rnd >> 17);
        rnd = rnd ^ (rnd << 5);
        return rnd;
    endfunction

    task automatic model_reset();
        m_tmr = 0; m_pre = 0; m_prev = '0; m_ovf = 0; m_irq = 0;
        mq.delete();
        for (int i = 0; i < 4; i++) begin m_mode[i] = 2'd0; m_cnt[i] = 0; end
    endtask

    // one clock: predict, advance, compare every output
    task automatic step(input logic rd);
        logic [3:0] hits;
        int pre_sz, after_rd;
        bit pushed, loaded;
        b_rd = rd;
        hits = '0;
        for (int i = 0; i < 4; i++) begin
            logic r, f, chg;
            logic [1:0] md;
            md  = b_mode[2*i +: 2];
            r   = b_line[i] & ~m_prev[i];
            f   = ~b_line[i] & m_prev[i];
            chg = (md != m_mode[i]);
            if (b_en[i]) begin
                if (md == 2'd0 && r) hits[i] = 1'b1;
                if (md == 2'd1 && f) hits[i] = 1'b1;
                if (md == 2'd2 && (r || f)) hits[i] = 1'b1;
            end
            if (chg) m_cnt[i] = 0;
            else if (b_en[i] && md == 2'd3 && r) begin
                m_cnt[i]++;
                if (m_cnt[i] == 8) begin hits[i] = 1'b1; m_cnt[i] = 0; end
            end
            m_prev[i] = b_line[i];
            m_mode[i] = md;
        end
        pre_sz = mq.size();
        if (rd && pre_sz > 0) void'(mq.pop_front());
        after_rd = mq.size();
        pushed = 0;
        if (hits != '0) begin
            if (mq.size() < 8) begin
                mq.push_back({hits, m_tmr[15:0]});
                pushed = (after_rd > 0);
            end else m_ovf = 1;
        end
        loaded = (mq.size() > 0) && (pre_sz == 0 || rd);
        m_irq = b_sel ? (pushed && mq.size() == 7) : loaded;
        if (m_pre == 7) begin m_pre = 0; m_tmr = (m_tmr + 1) % 65536; end
        else m_pre++;
        @(posedge clk);
        @(negedge clk);
        b_rd = 1'b0;
        chk(timer == m_tmr[15:0], "R4 timer", timer, m_tmr);
        chk(hold_vld == (mq.size() > 0), "R6 hold valid", hold_vld, mq.size());
        if (mq.size() > 0) chk(hold_data == mq[0], "R5 hold entry", hold_data, mq[0]);
        chk(ovf == m_ovf, "R7 overflow", ovf, m_ovf);
        if (b_sel) chk(irq == m_irq, "R9 sixth-entry irq", irq, m_irq);
        else       chk(irq == m_irq, "R8 load irq", irq, m_irq);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(hold_vld == 1'b0, "R10 hold valid in reset", hold_vld, 0);
        chk(irq == 1'b0, "R10 irq in reset", irq, 0);
        chk(ovf == 1'b0, "R10 ovf in reset", ovf, 0);
        chk(timer == 16'd0, "R10 timer in reset", timer, 0);
        rst_n = 1'b1;
    endtask

    task automatic pulse(input int ln);
        b_line[ln] = 1'b1; step(1'b0);
        b_line[ln] = 1'b0; step(1'b0);
    endtask

    task automatic drain();
        while (hold_vld) step(1'b1);
    endtask

    initial begin
        do_reset();
        step(1'b0);
        chk(timer == 16'd0, "R10 timer after reset", timer, 0);

        // R2: rising on line 0, falling on line 1, both on line 2
        b_en = 4'b0111;
        b_mode = {2'd0, 2'd2, 2'd1, 2'd0};
        repeat (9) step(1'b0);
        pulse(0);
        pulse(1);
        pulse(2);
        chk(hold_vld == 1'b1, "R2 rising edge captured", hold_vld, 1);
        chk(hold_data[19:16] == 4'b0001, "R2 first mask is line 0", hold_data[19:16], 1);
        drain();
        // R5: simultaneous edges share one entry
        b_line = 4'b0111; step(1'b0);
        b_line = 4'b0000; step(1'b0);
        chk(hold_data[19:16] == 4'b0101, "R5 merged mask", hold_data[19:16], 5);
        drain();

        // R1: a disabled line does nothing
        b_en = 4'b0000;
        repeat (4) pulse(3);
        chk(hold_vld == 1'b0, "R1 disabled line ignored", hold_vld, 0);
        // R6: read with nothing held is ignored
        step(1'b1);
        chk(hold_vld == 1'b0, "R6 empty read", hold_vld, 0);

        // R3: every eighth rising edge on line 3
        b_en = 4'b1000;
        b_mode = {2'd3, 6'd0};
        step(1'b0);
        repeat (7) pulse(3);
        chk(hold_vld == 1'b0, "R3 seven edges no capture", hold_vld, 0);
        pulse(3);
        chk(hold_vld == 1'b1, "R3 eighth edge captures", hold_vld, 1);
        chk(hold_data[19:16] == 4'b1000, "R3 mask", hold_data[19:16], 8);
        drain();
        repeat (3) pulse(3);
        b_mode = 8'd0; step(1'b0);
        b_mode = {2'd3, 6'd0}; step(1'b0);
        repeat (7) pulse(3);
        chk(hold_vld == 1'b0, "R3 count cleared by mode change", hold_vld, 0);
        pulse(3);
        chk(hold_vld == 1'b1, "R3 eighth edge after clear", hold_vld, 1);
        drain();

        // R9 and R7: fill up with the sixth-entry interrupt selected
        b_sel = 1'b1;
        b_en = 4'b0001;
        b_mode = 8'd0;
        repeat (10) pulse(0);
        chk(ovf == 1'b1, "R7 overflow after ten events", ovf, 1);
        // R7: read and event together when full keeps the event
        b_line[0] = 1'b1; step(1'b1);
        b_line[0] = 1'b0; step(1'b0);
        drain();
        chk(ovf == 1'b1, "R7 overflow stays set", ovf, 1);
        b_sel = 1'b0;

        // mixed stimulus against the reference
        do_reset();
        for (int c = 0; c < 4000; c++) begin
            logic [31:0] v;
            v = rand32();
            if (v[3:0] == 4'd0) b_mode = rand32()[7:0];
            if (v[7:4] == 4'd0) b_en = rand32()[3:0];
            if (v[11:8] == 4'd0) b_sel = ~b_sel;
            if (v[13:12] == 2'd0) b_line = b_line ^ rand32()[3:0];
            step(v[16:14] == 3'd0 || (c > 2000 && v[15:14] != 2'd0));
        end
        drain();

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule